// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads a configuration bitstream into an FPGA that listens on a passive serial port. On a `start` pulse it pulls the active-low configuration request low for a fixed number of system clocks. It checks that the target has answered by pulling its active-low status line low, and then releases the request. It waits for the status line to come back high. It then shifts each incoming byte out on one data line, least significant bit first, using a serial clock that it generates itself.

Bytes arrive over a valid/ready interface. The last byte is tagged with `byte_last`. After the final data bit the host keeps clocking until the target raises its done flag, and then parks the serial clock and the data line low. Every failure path ends in an error state with a code that names the cause. Any later `start` pulse retries the whole sequence.

The target's status and done inputs pass through a two-flop synchronizer. All timing windows are counted in system clock cycles, and each window is set by a parameter.

Top module: `ps_cfg_host`

## Requirements
- R1: While reset is held and after it is released, `cfg_req_n` is 1, `cfg_dclk` is 0, `cfg_data` is 0, and `busy`, `done`, `error` and `byte_ready` are 0.
- R2: A `start` pulse while not busy drives `cfg_req_n` low for exactly `REQ_LOW_CYC` consecutive clock cycles.
- R3: If the synchronized status line is not low when the request pulse ends, the host stops with `error`=1 and `err_code`=1, and issues no serial clock edge.
- R4: After the request is released, the host waits for the status line to go high. If it is not high within `STATUS_WAIT_CYC` cycles, the host stops with `err_code`=2 and issues no serial clock edge. A status that rises inside the window lets loading proceed.
- R5: Each accepted byte is sent as eight bits, bit 0 first, one bit per rising edge of `cfg_dclk`. The bytes are sent in the order they were accepted.
- R6: Every high phase of `cfg_dclk` lasts exactly `HALF_CYC` cycles, and every low phase lasts at least `HALF_CYC` cycles. `cfg_data` changes only in a cycle where `cfg_dclk` is low.
- R7: `byte_ready` is 1 only while loading, with the shift register empty and `cfg_dclk` low. It is never 1 in the middle of a byte.
- R8: If the status line goes low while bits are being shifted, or while waiting for done, the host stops clocking and ends with `err_code`=3.
- R9: After the last data bit the host keeps toggling `cfg_dclk` until the synchronized done flag is high. It then ends with `done`=1, `error`=0 and `err_code`=0.
- R10: If done is still low after `FLUSH_CLKS` extra rising edges, the host ends with `err_code`=4. Exactly `FLUSH_CLKS` extra edges are issued in that case.
- R11: Once `done` or `error` is 1, `cfg_dclk` and `cfg_data` are held at 0 and `cfg_req_n` at 1.
- R12: `busy` is 1 from the cycle after an accepted `start` until the host reaches `done` or `error`.
- R13: A `start` after an error runs a complete new cycle, which can finish with `done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a configuration cycle |
| byte_data | input | 8 | Bitstream byte |
| byte_valid | input | 1 | `byte_data` is valid |
| byte_last | input | 1 | Current byte is the last of the stream |
| byte_ready | output | 1 | Host accepts a byte this cycle |
| cfg_status_n | input | 1 | Target status line, active low |
| cfg_done | input | 1 | Target done flag |
| cfg_req_n | output | 1 | Configuration request to target, active low |
| cfg_dclk | output | 1 | Serial clock to target |
| cfg_data | output | 1 | Serial data to target |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Last cycle finished successfully |
| error | output | 1 | Last cycle failed |
| err_code | output | 3 | Failure cause: 0 none, 1 no answer, 2 status timeout, 3 status lost, 4 done timeout |

## Verification
A shift counter or shift register left in the wrong state shows up at the target model within one byte time. It appears as a wrong reassembled byte, a high phase of the wrong length, or `byte_ready` appearing in the middle of a byte. A sequencing fault shows up on the request line or in `err_code` once the pulse or window ends. A stuck request pulse is seen as a wrong low-run length after `REQ_LOW_CYC` cycles. A failure to park shows up in the idle cycles right after `done` or `error`, as clock edges or data activity.

// File: rtl/ps_cfg_host.sv
module ps_cfg_host #(
  parameter int REQ_LOW_CYC     = 50,
  parameter int STATUS_WAIT_CYC = 23000,
  parameter int HALF_CYC        = 2,
  parameter int FLUSH_CLKS      = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_data,
  input  logic       byte_valid,
  input  logic       byte_last,
  output logic       byte_ready,
  input  logic       cfg_status_n,
  input  logic       cfg_done,
  output logic       cfg_req_n,
  output logic       cfg_dclk,
  output logic       cfg_data,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [2:0] err_code
);

  localparam int WAIT_MAX = (REQ_LOW_CYC > STATUS_WAIT_CYC) ? REQ_LOW_CYC : STATUS_WAIT_CYC;
  localparam int CW = $clog2(WAIT_MAX + 1);
  localparam int PW = $clog2(HALF_CYC + 1);
  localparam int FW = $clog2(FLUSH_CLKS + 1);
  localparam logic [CW-1:0] REQ_END  = CW'(REQ_LOW_CYC - 1);
  localparam logic [CW-1:0] WAIT_END = CW'(STATUS_WAIT_CYC - 1);
  localparam logic [PW-1:0] PH_END   = PW'(HALF_CYC - 1);
  localparam logic [FW-1:0] FL_END   = FW'(FLUSH_CLKS - 1);

  localparam logic [2:0] E_NONE = 3'd0, E_NOACK = 3'd1, E_WAIT = 3'd2,
                         E_LOST = 3'd3, E_DONE = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_SHIFT, S_FLUSH, S_OK, S_FAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [FW-1:0] fl_n;
  logic [3:0]    nbits;
  logic [7:0]    sreg;
  logic          last_q, dclk_q;
  logic [2:0]    err_q;
  logic          st_m, st_s, dn_m, dn_s;

  wire ph_end = (ph == PH_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_m <= 1'b0; st_s <= 1'b0; dn_m <= 1'b0; dn_s <= 1'b0;
    end else begin
      st_m <= cfg_status_n; st_s <= st_m;
      dn_m <= cfg_done;     dn_s <= dn_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= '0;
      fl_n   <= '0;
      nbits  <= '0;
      sreg   <= '0;
      last_q <= 1'b0;
      dclk_q <= 1'b0;
      err_q  <= E_NONE;
    end else begin
      case (st)
        S_IDLE, S_OK, S_FAIL: begin
          if (start) begin
            st     <= S_REQ;
            cnt    <= '0;
            err_q  <= E_NONE;
            sreg   <= '0;
            nbits  <= '0;
            dclk_q <= 1'b0;
          end
        end
        S_REQ: begin
          if (cnt == REQ_END) begin
            cnt <= '0;
            if (!st_s) st <= S_WAIT;
            else begin st <= S_FAIL; err_q <= E_NOACK; end
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: begin
          if (st_s) begin
            st     <= S_SHIFT;
            ph     <= '0;
            nbits  <= '0;
            last_q <= 1'b0;
          end else if (cnt == WAIT_END) begin
            st    <= S_FAIL;
            err_q <= E_WAIT;
          end else cnt <= cnt + 1'b1;
        end
        S_SHIFT: begin
          if (!st_s) begin
            st <= S_FAIL; err_q <= E_LOST;
            dclk_q <= 1'b0; sreg <= '0; nbits <= '0;
          end else if (nbits == 4'd0) begin
            if (byte_valid) begin
              sreg   <= byte_data;
              nbits  <= 4'd8;
              last_q <= byte_last;
              ph     <= '0;
            end
          end else if (ph_end) begin
            ph <= '0;
            if (!dclk_q) dclk_q <= 1'b1;
            else begin
              dclk_q <= 1'b0;
              sreg   <= {1'b0, sreg[7:1]};
              nbits  <= nbits - 4'd1;
              if (nbits == 4'd1 && last_q) begin
                st   <= S_FLUSH;
                fl_n <= '0;
              end
            end
          end else ph <= ph + 1'b1;
        end
        S_FLUSH: begin
          if (!st_s) begin
            st <= S_FAIL; err_q <= E_LOST; dclk_q <= 1'b0;
          end else if (dn_s && !dclk_q) begin
            st <= S_OK;
          end else if (ph_end) begin
            ph <= '0;
            if (!dclk_q) dclk_q <= 1'b1;
            else begin
              dclk_q <= 1'b0;
              if (fl_n == FL_END) begin
                if (dn_s) st <= S_OK;
                else begin st <= S_FAIL; err_q <= E_DONE; end
              end else fl_n <= fl_n + 1'b1;
            end
          end else ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign byte_ready = (st == S_SHIFT) && (nbits == 4'd0) && st_s;
  assign cfg_req_n  = (st != S_REQ);
  assign cfg_dclk   = dclk_q;
  assign cfg_data   = sreg[0];
  assign busy       = (st == S_REQ) || (st == S_WAIT) || (st == S_SHIFT) || (st == S_FLUSH);
  assign done       = (st == S_OK);
  assign error      = (st == S_FAIL);
  assign err_code   = err_q;

endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_ready,
  input logic       cfg_status_n,
  input logic       cfg_req_n,
  input logic       cfg_dclk,
  input logic       cfg_data,
  input logic       busy,
  input logic       done,
  input logic [2:0] err_code,
  input logic       error
);

  assert_data_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_data) |-> !cfg_dclk);

  assert_ready_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (!cfg_dclk && busy));

  assert_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!cfg_dclk && !cfg_data && cfg_req_n));

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 3'd0));

  assert_req_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_req_n) |=> !cfg_req_n);

  assert_clk_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_dclk) |-> $past(cfg_status_n, 3));

  assert_busy_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_req_n || cfg_dclk) |-> busy);

endmodule

bind ps_cfg_host ps_cfg_host_chk chk_i (
  .clk(clk), .rst_n(rst_n), .byte_ready(byte_ready), .cfg_status_n(cfg_status_n),
  .cfg_req_n(cfg_req_n), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data), .busy(busy),
  .done(done), .err_code(err_code), .error(error)
);

// File: tb/ps_cfg_host_tb_top.sv
module ps_cfg_host_tb_top;
  localparam int REQ = 20, TO = 200, HALF = 2, FL = 16;
  localparam int ACK_DLY = 3, DONE_LAT = 3;
  localparam int F_NONE = 0, F_NOACK = 1, F_STUCK = 2, F_DROP = 3, F_NODONE = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_valid = 1'b0, byte_last = 1'b0;
  logic byte_ready, cfg_req_n, cfg_dclk, cfg_data, busy, done, error;
  logic [2:0] err_code;
  logic tgt_st = 1'b0, tgt_dn = 1'b0;

  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  ps_cfg_host #(.REQ_LOW_CYC(REQ), .STATUS_WAIT_CYC(TO), .HALF_CYC(HALF), .FLUSH_CLKS(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_last(byte_last), .byte_ready(byte_ready), .cfg_status_n(tgt_st), .cfg_done(tgt_dn),
    .cfg_req_n(cfg_req_n), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data), .busy(busy),
    .done(done), .error(error), .err_code(err_code));

  // target model state
  int fault = F_NONE, drop_at = 0, low_hold = 40, exp_n = 0;
  int t_hold = 0, req_run = 0, req_len = 0;
  int rx_bits = 0, rx_n = 0, extra = 0, rises = 0;
  int hi_run = 0, lo_run = 0, bad_phase = 0, bad_ready = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] rx_mem [0:15];
  logic [7:0] mem [0:15];
  logic pd = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_req_n) begin
        req_run++;
        tgt_dn = 1'b0;
        t_hold = 0;
        if (req_run == ACK_DLY && fault != F_NOACK) tgt_st = 1'b0;
      end else begin
        if (req_run != 0) req_len = req_run;
        req_run = 0;
        if (!tgt_st && fault != F_STUCK && !(fault == F_DROP && rises >= drop_at)) begin
          t_hold++;
          if (t_hold >= low_hold) tgt_st = 1'b1;
        end
      end
      if (cfg_dclk && !pd) begin
        rises++;
        if (rx_n < exp_n) begin
          rx_sh = {cfg_data, rx_sh[7:1]};
          rx_bits++;
          if (rx_bits == 8) begin rx_mem[rx_n] = rx_sh; rx_n++; rx_bits = 0; end
        end else extra++;
        if (fault == F_DROP && rises == drop_at) tgt_st = 1'b0;
      end
      if (fault != F_NODONE && exp_n > 0 && rx_n == exp_n && extra >= DONE_LAT) tgt_dn = 1'b1;
      if (cfg_dclk) begin
        if (lo_run != 0 && lo_run < HALF) bad_phase++;
        lo_run = 0; hi_run++;
      end else begin
        if (hi_run != 0 && hi_run != HALF) bad_phase++;
        hi_run = 0; lo_run++;
      end
      if (byte_ready && (cfg_dclk || rx_bits != 0)) bad_ready++;
      pd = cfg_dclk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int f);
    case (f)
      F_NOACK:  return 1;
      F_STUCK:  return 2;
      F_DROP:   return 3;
      F_NODONE: return 4;
      default:  return 0;
    endcase
  endfunction

  task automatic run_cfg(input int n, input int f, input int drop, input int hold);
    int idx, guard, r0;
    @(posedge clk); #2;
    fault = f; drop_at = drop; low_hold = hold; exp_n = n;
    rx_n = 0; rx_bits = 0; extra = 0; rises = 0; bad_phase = 0; bad_ready = 0;
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !cfg_req_n, "R12 busy+req after start", {30'd0, busy, cfg_req_n}, 2);
    idx = 0; guard = 0;
    while (idx < n && !error && guard < 20000) begin
      @(negedge clk); guard++;
      byte_valid = ($urandom % 4) != 0;
      byte_data  = mem[idx];
      byte_last  = (idx == n - 1);
      if (byte_valid && byte_ready) idx++;
    end
    @(negedge clk); byte_valid = 1'b0; byte_last = 1'b0;
    guard = 0;
    while (!done && !error && guard < 5000) begin @(negedge clk); guard++; end
    check(req_len == REQ, "R2 request low width", req_len, REQ);
    check(int'(err_code) == exp_code(f), "R3/R4/R8/R10 err_code", int'(err_code), exp_code(f));
    check(done == (f == F_NONE) && error == (f != F_NONE), "R9/R13 end state",
          {30'd0, done, error}, (f == F_NONE) ? 2 : 1);
    check(!busy, "R12 busy cleared", int'(busy), 0);
    r0 = rises;
    repeat (12) @(negedge clk);
    check(rises == r0 && !cfg_dclk && !cfg_data && cfg_req_n, "R11 parked after end", rises - r0, 0);
    check(bad_phase == 0, "R6 clock phase lengths", bad_phase, 0);
    check(bad_ready == 0, "R7 ready only between bytes", bad_ready, 0);
    case (f)
      F_NOACK, F_STUCK: check(rises == 0, "R3/R4 no serial clock", rises, 0);
      F_DROP: check(rises <= drop + 1 && rx_n < n, "R8 shifting stopped", rises, drop);
      F_NODONE: check(extra == FL, "R10 extra clocks", extra, FL);
      default: begin
        check(extra >= DONE_LAT && extra <= DONE_LAT + 1, "R9 clocks until done", extra, DONE_LAT);
        check(rx_n == n, "R5 byte count", rx_n, n);
        for (int i = 0; i < n; i++)
          check(rx_mem[i] == mem[i], "R5 byte value bit0 first", int'(rx_mem[i]), int'(mem[i]));
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(cfg_req_n && !cfg_dclk && !cfg_data && !busy && !done && !error && !byte_ready,
          "R1 outputs in reset", 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_req_n && !cfg_dclk && !cfg_data && !busy && !done && !error && !byte_ready,
          "R1 outputs after reset", 0, 0);
    run_cfg(1, F_NONE, 0, 10);
    run_cfg(3, F_NOACK, 0, 10);
    run_cfg(2, F_NONE, 0, 10);            // R13 retry after error
    run_cfg(2, F_STUCK, 0, 10);
    run_cfg(2, F_NONE, 0, TO - 10);       // R4 status rises late in window
    run_cfg(4, F_DROP, 12, 10);
    run_cfg(1, F_NONE, 0, 10);            // R13 retry after status loss
    run_cfg(2, F_NODONE, 0, 10);
    for (int k = 0; k < 10; k++)
      run_cfg(1 + int'($urandom % 8), F_NONE, 0, 5 + int'($urandom % 150));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule